// File: doc/BRIEF.md
# Shared-RAM Endpoint FIFO CPU Port

This block gives a processor byte-wide access to the FIFOs of five USB endpoints. The FIFOs are cut out of one shared 1024-byte RAM. There is one control endpoint and four general endpoints, named a to d. Each endpoint owns one contiguous region of the RAM. The regions are packed upward from address 0 in the fixed order control, a, b, c, d. Each region is exactly as long as the size given for it on a configuration input. The control endpoint's size is its maximum packet size.

Software picks an endpoint for reading and, separately, an endpoint for writing. It does this by writing two join-select registers. A single data-port register then does the transfer:

- A read pops one byte from the read-joined endpoint's FIFO.
- A write pushes one byte into the write-joined endpoint's FIFO.

A remaining-byte count output always shows how many bytes the read-joined FIFO holds. If the configured sizes add up to more than the RAM holds, an error flag rises. Every endpoint whose region runs past the top of the RAM is then locked out.

The block is pure datapath: join registers, per-endpoint pointer and count registers, the RAM and a registered read-data path. It has no sequencing state machine. Every register access completes in the cycle it is presented. Read data appears on `reg_rdata` one clock after the read request and holds until the next read.

Top module: `epf_cpu_port`

## Requirements
- R1: After reset, both join registers read as 0, `reg_rdata` is 0, every FIFO is empty (`rd_remain` = 0) and `cfg_err` is 0 for a configuration that fits.
- R2: Register select 0 is the read-join register and 1 is the write-join register. In each, bit i (i = 0..3) joins general endpoint i+1 (a..d). A write keeps only the highest-order set bit among bits 3..0. Bits 7..4 are discarded and always read back as 0.
- R3: When a join register holds 0, the control endpoint (endpoint 0) is the one joined for that direction.
- R4: A write to the data port (select 2) stores the byte in the write-joined endpoint's region and raises its count by one. The write is ignored when the count equals the region size.
- R5: A read of the data port returns the oldest byte of the read-joined endpoint and lowers its count by one. Bytes come out in write order, including after the pointers wrap around within the region.
- R6: A data-port read when the read-joined FIFO is empty returns 0 and changes no count.
- R7: A data-port read is honoured only while `rd_enable[e]` is 1 for the read-joined endpoint e. Otherwise it returns 0 and leaves that FIFO unchanged.
- R8: `rd_remain` always equals the number of bytes held by the read-joined endpoint. It follows a change of the read-join register in the next cycle.
- R9: Endpoint regions are laid out contiguously from address 0 in the order control, a, b, c, d, each as long as its configured size. Data written to one endpoint is never seen through another. A configuration totalling exactly 1024 bytes uses addresses up to 0x3FF.
- R10: When the configured sizes sum past 1024, `cfg_err` is 1. Every endpoint whose region ends beyond 1024 ignores writes, and reads from it return 0. Endpoints that fit keep working.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 read-join, 1 write-join, 2 data port, 3 unused (reads 0) |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe; ignored when `reg_wr` is also high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after `reg_rd` |
| ep_size | input | 55 | Region sizes, 11 bits each; endpoint e at bits [11e+10:11e], 0 = control, 1..4 = a..d |
| rd_enable | input | 5 | Per-endpoint read-access enable, bit e for endpoint e |
| rd_remain | output | 11 | Byte count of the read-joined endpoint |
| cfg_err | output | 1 | Region sizes overflow the RAM |

## Verification
The assertions assume that `ep_size` stays constant between resets. They also assume that `reg_rd` and `reg_wr` are never raised together. Under those two assumptions, counts stay within their region size, and no push or pop reaches a FIFO that is full, empty, disabled or locked out. The stimulus changes the size configuration only while reset is held, and it issues exactly one register access per cycle. A behavioural model built from queues predicts `rd_remain` and `cfg_err` on every clock and predicts each returned byte.

// File: rtl/epf_pkg.sv
package epf_pkg;
    typedef enum logic [1:0] {
        REG_RD_JOIN = 2'd0,
        REG_WR_JOIN = 2'd1,
        REG_DATA    = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/epf_join_sel.sv
module epf_join_sel #(
    parameter int NUM_GEN = 4,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_GEN-1:0] wdata,
    output logic [NUM_GEN-1:0] sel_q,
    output logic [IDX_W-1:0]   ep_idx
);
    logic [NUM_GEN-1:0] resolved;

    // keep only the highest-order set bit
    always_comb begin
        resolved = '0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (wdata[i]) begin
                resolved    = '0;
                resolved[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (load)
            sel_q <= resolved;
    end

    // endpoint 0 is the control endpoint, joined when nothing is selected
    always_comb begin
        ep_idx = '0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (sel_q[i])
                ep_idx = IDX_W'(i + 1);
        end
    end

    assert_top_bit_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sel_q[NUM_GEN-1] == $past(wdata[NUM_GEN-1]));

    assert_default_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wdata == '0) |=> ep_idx == '0);
endmodule

// File: rtl/epf_region_map.sv
module epf_region_map #(
    parameter int NUM_EP    = 5,
    parameter int CNT_W     = 11,
    parameter int SUM_W     = 15,
    parameter int RAM_BYTES = 1024
) (
    input  logic [NUM_EP-1:0][CNT_W-1:0] sizes,
    output logic [NUM_EP-1:0][SUM_W-1:0] bases,
    output logic [NUM_EP-1:0]            blocked,
    output logic                         cfg_err
);
    logic [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            bases[e]   = acc;
            acc        = acc + SUM_W'(sizes[e]);
            blocked[e] = acc > SUM_W'(RAM_BYTES);
        end
    end

    assign cfg_err = |blocked;
endmodule

// File: rtl/epf_ep_ctr.sv
module epf_ep_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] size,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] rptr,
    output logic [CNT_W-1:0] wptr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] rptr_inc, wptr_inc;

    assign rptr_inc = rptr + CNT_W'(1);
    assign wptr_inc = wptr + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr  <= (wptr_inc == size) ? '0 : wptr_inc;
                count <= count + CNT_W'(1);
            end else if (pop) begin
                rptr  <= (rptr_inc == size) ? '0 : rptr_inc;
                count <= count - CNT_W'(1);
            end
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size);

    assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < size);

    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);

    assert_rptr_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size != '0) |-> rptr < size);
endmodule

// File: rtl/epf_cpu_port.sv
module epf_cpu_port #(
    parameter int RAM_BYTES = 1024,
    parameter int NUM_GEN   = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = $clog2(RAM_BYTES),
    parameter int CNT_W     = ADDR_W + 1,
    parameter int NUM_EP    = NUM_GEN + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              reg_sel,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [NUM_EP*CNT_W-1:0] ep_size,
    input  logic [NUM_EP-1:0]       rd_enable,
    output logic [CNT_W-1:0]        rd_remain,
    output logic                    cfg_err
);
    import epf_pkg::*;

    localparam int IDX_W = $clog2(NUM_EP);
    localparam int SUM_W = CNT_W + IDX_W + 1;

    reg_sel_e                     sel;
    logic                         is_data_wr, is_data_rd, do_read;
    logic [NUM_EP-1:0][CNT_W-1:0] sizes;
    logic [NUM_EP-1:0][SUM_W-1:0] bases;
    logic [NUM_EP-1:0]            blocked;
    logic [NUM_GEN-1:0]           rd_sel_q, wr_sel_q;
    logic [IDX_W-1:0]             rd_ep, wr_ep;
    logic [NUM_EP-1:0][CNT_W-1:0] rptr, wptr, count;
    logic [NUM_EP-1:0]            push, pop;
    logic                         rd_ok, wr_ok;
    logic [ADDR_W-1:0]            rd_addr, wr_addr;
    logic [DATA_W-1:0]            mem [RAM_BYTES];

    assign sel        = reg_sel_e'(reg_sel);
    assign do_read    = reg_rd && !reg_wr;
    assign is_data_wr = reg_wr && (sel == REG_DATA);
    assign is_data_rd = do_read && (sel == REG_DATA);
    assign sizes      = ep_size;

    epf_region_map #(
        .NUM_EP(NUM_EP), .CNT_W(CNT_W), .SUM_W(SUM_W), .RAM_BYTES(RAM_BYTES)
    ) u_map (
        .sizes(sizes), .bases(bases), .blocked(blocked), .cfg_err(cfg_err)
    );

    epf_join_sel #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_rd_join (
        .clk(clk), .rst_n(rst_n),
        .load(reg_wr && sel == REG_RD_JOIN),
        .wdata(reg_wdata[NUM_GEN-1:0]),
        .sel_q(rd_sel_q), .ep_idx(rd_ep)
    );

    epf_join_sel #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_wr_join (
        .clk(clk), .rst_n(rst_n),
        .load(reg_wr && sel == REG_WR_JOIN),
        .wdata(reg_wdata[NUM_GEN-1:0]),
        .sel_q(wr_sel_q), .ep_idx(wr_ep)
    );

    assign rd_ok = is_data_rd && rd_enable[rd_ep] && !blocked[rd_ep]
                   && (count[rd_ep] != '0);
    assign wr_ok = is_data_wr && !blocked[wr_ep]
                   && (count[wr_ep] < sizes[wr_ep]);

    genvar e;
    generate
        for (e = 0; e < NUM_EP; e++) begin : g_ep
            assign push[e] = wr_ok && (wr_ep == IDX_W'(e));
            assign pop[e]  = rd_ok && (rd_ep == IDX_W'(e));
            epf_ep_ctr #(.CNT_W(CNT_W)) u_ctr (
                .clk(clk), .rst_n(rst_n), .size(sizes[e]),
                .push(push[e]), .pop(pop[e]),
                .rptr(rptr[e]), .wptr(wptr[e]), .count(count[e])
            );
        end
    endgenerate

    assign rd_addr   = ADDR_W'(bases[rd_ep] + SUM_W'(rptr[rd_ep]));
    assign wr_addr   = ADDR_W'(bases[wr_ep] + SUM_W'(wptr[wr_ep]));
    assign rd_remain = count[rd_ep];

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wr_addr] <= reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (do_read) begin
            unique case (sel)
                REG_RD_JOIN: reg_rdata <= DATA_W'(rd_sel_q);
                REG_WR_JOIN: reg_rdata <= DATA_W'(wr_sel_q);
                REG_DATA:    reg_rdata <= rd_ok ? mem[rd_addr] : '0;
                REG_NONE:    reg_rdata <= '0;
            endcase
        end
    end

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_rd && count[rd_ep] == '0) |=> reg_rdata == '0);

    assert_disabled_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_rd && !rd_enable[rd_ep]) |=> (reg_rdata == '0 && $stable(rd_remain)));

    assert_blocked_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_wr && blocked[wr_ep] && wr_ep == rd_ep) |=> $stable(rd_remain));
endmodule

// File: tb/epf_cpu_port_tb.sv
module epf_cpu_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NEP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [54:0] ep_size = '0;
    logic [4:0]  rd_enable = 5'b11111;
    logic [10:0] rd_remain;
    logic        cfg_err;

    int tests = 0, fails = 0;
    bit checking = 1'b0;

    logic [7:0] mq [NEP][$];
    int         msize [NEP];
    bit         mblk [NEP];
    bit         merr;
    logic [3:0] mrj, mwj;
    logic [7:0] exp_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    epf_cpu_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ep_size(ep_size), .rd_enable(rd_enable), .rd_remain(rd_remain),
        .cfg_err(cfg_err)
    );

    function automatic int oh_idx(logic [3:0] v);
        int r = 0;
        for (int i = 0; i < 4; i++) if (v[i]) r = i + 1;
        return r;
    endfunction

    function automatic logic [3:0] resolve(logic [7:0] d);
        logic [3:0] r = '0;
        for (int i = 0; i < 4; i++) if (d[i]) begin r = '0; r[i] = 1'b1; end
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R8: remaining count and error flag compared every clock
    always @(negedge clk) begin
        if (rst_n && checking) begin
            chk("R8 rd_remain", int'(rd_remain), mq[oh_idx(mrj)].size());
            chk("R10 cfg_err", int'(cfg_err), int'(merr));
        end
    end

    task automatic model(input logic w, input logic r, input logic [1:0] s, input logic [7:0] d);
        int e;
        if (w) begin
            case (s)
                2'd0: mrj = resolve(d);
                2'd1: mwj = resolve(d);
                2'd2: begin
                    e = oh_idx(mwj);
                    if (!mblk[e] && mq[e].size() < msize[e]) mq[e].push_back(d);
                end
                default: ;
            endcase
        end else if (r) begin
            case (s)
                2'd0: exp_rd = {4'b0, mrj};
                2'd1: exp_rd = {4'b0, mwj};
                2'd2: begin
                    e = oh_idx(mrj);
                    if (rd_enable[e] && !mblk[e] && mq[e].size() > 0)
                        exp_rd = mq[e].pop_front();
                    else
                        exp_rd = 8'h00;
                end
                default: exp_rd = 8'h00;
            endcase
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        model(w, r, s, d);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        op(1'b1, 1'b0, s, d);
    endtask

    task automatic rd(input logic [1:0] s, input string req);
        op(1'b0, 1'b1, s, 8'h00);
        @(negedge clk);
        chk(req, int'(reg_rdata), int'(exp_rd));
    endtask

    task automatic do_reset(input int s0, input int s1, input int s2, input int s3, input int s4);
        int acc = 0;
        checking = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        msize[0] = s0; msize[1] = s1; msize[2] = s2; msize[3] = s3; msize[4] = s4;
        merr = 1'b0;
        for (int e = 0; e < NEP; e++) begin
            ep_size[e*11 +: 11] = 11'(msize[e]);
            acc += msize[e];
            mblk[e] = acc > 1024;
            if (mblk[e]) merr = 1'b1;
            mq[e].delete();
        end
        mrj = '0; mwj = '0; exp_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // configuration A: 8,16,4,32,64
        do_reset(8, 16, 4, 32, 64);
        @(negedge clk);
        chk("R1 rdata", int'(reg_rdata), 0);
        chk("R1 rd_remain", int'(rd_remain), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        rd(2'd0, "R1 rd-join reset");
        chk("R1 rd-join value", int'(reg_rdata), 0);
        rd(2'd1, "R1 wr-join reset");

        // R2: priority and reserved bits
        wr(2'd0, 8'hF6); rd(2'd0, "R2 rd-join F6");
        chk("R2 F6 -> 04", int'(reg_rdata), 4);
        wr(2'd0, 8'h0B); rd(2'd0, "R2 rd-join 0B");
        chk("R2 0B -> 08", int'(reg_rdata), 8);
        wr(2'd1, 8'h03); rd(2'd1, "R2 wr-join 03");
        chk("R2 03 -> 02", int'(reg_rdata), 2);
        wr(2'd1, 8'hF0); rd(2'd1, "R2 wr-join F0");
        chk("R2 F0 -> 00", int'(reg_rdata), 0);

        // R3: control endpoint by default
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd2, 8'h33);
        @(negedge clk);
        chk("R3 ctrl count", int'(rd_remain), 3);
        rd(2'd2, "R3 ctrl read"); rd(2'd2, "R5 ctrl read"); rd(2'd2, "R5 ctrl read");
        chk("R5 ctrl last byte", int'(reg_rdata), 8'h33);

        // R4, R5, R6 on endpoint b (size 4)
        wr(2'd1, 8'h02); wr(2'd0, 8'h02);
        for (int i = 0; i < 6; i++) wr(2'd2, 8'(8'h40 + i));
        @(negedge clk);
        chk("R4 full count", int'(rd_remain), 4);
        for (int i = 0; i < 4; i++) rd(2'd2, "R5 fifo order b");
        rd(2'd2, "R6 empty read");
        chk("R6 empty value", int'(reg_rdata), 0);
        for (int i = 0; i < 3; i++) wr(2'd2, 8'(8'h50 + i));
        for (int i = 0; i < 3; i++) rd(2'd2, "R5 wrap b");

        // R9: isolation among a, c, d
        wr(2'd1, 8'h01); wr(2'd2, 8'hA1); wr(2'd2, 8'hA2);
        wr(2'd1, 8'h04); wr(2'd2, 8'hC1); wr(2'd2, 8'hC2);
        wr(2'd1, 8'h08); wr(2'd2, 8'hD1); wr(2'd2, 8'hD2);
        wr(2'd0, 8'h01); rd(2'd2, "R9 a"); rd(2'd2, "R9 a");
        chk("R9 a second", int'(reg_rdata), 8'hA2);
        wr(2'd0, 8'h08); rd(2'd2, "R9 d"); rd(2'd2, "R9 d");
        wr(2'd0, 8'h04); rd(2'd2, "R9 c");

        // R7: read enable for c (endpoint 3)
        rd_enable = 5'b10111;
        rd(2'd2, "R7 disabled read");
        chk("R7 disabled value", int'(reg_rdata), 0);
        chk("R7 count kept", int'(rd_remain), 1);
        rd_enable = 5'b11111;
        rd(2'd2, "R7 enabled read");
        chk("R7 enabled value", int'(reg_rdata), 8'hC2);

        // configuration B: overflow, c and d locked out
        do_reset(64, 512, 400, 100, 8);
        @(negedge clk);
        chk("R10 err raised", int'(cfg_err), 1);
        wr(2'd1, 8'h04); wr(2'd0, 8'h04);
        for (int i = 0; i < 5; i++) wr(2'd2, 8'(8'h60 + i));
        @(negedge clk);
        chk("R10 blocked count", int'(rd_remain), 0);
        rd(2'd2, "R10 blocked read");
        wr(2'd1, 8'h08); wr(2'd2, 8'h77);
        wr(2'd0, 8'h08); rd(2'd2, "R10 blocked d read");
        wr(2'd1, 8'h02); wr(2'd0, 8'h02);
        wr(2'd2, 8'h81); wr(2'd2, 8'h82);
        rd(2'd2, "R10 b works"); rd(2'd2, "R10 b works");
        chk("R10 b value", int'(reg_rdata), 8'h82);

        // configuration C: exactly 1024, d reaches 0x3FF
        do_reset(24, 500, 300, 100, 100);
        @(negedge clk);
        chk("R10 no err at 1024", int'(cfg_err), 0);
        wr(2'd1, 8'h08); wr(2'd0, 8'h08);
        for (int i = 0; i < 101; i++) wr(2'd2, 8'(i * 3 + 1));
        @(negedge clk);
        chk("R9 d full", int'(rd_remain), 100);
        for (int i = 0; i < 100; i++) rd(2'd2, "R9 top region");

        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule